// File: doc/BRIEF.md
# Time-of-Day Transfer Target Controller

This block sits inside a chip-level time-of-day unit. It records which processor core should receive the time-of-day value, and it launches the transfer of that value into the core's timebase. Software programs it through a single-cycle register write port. The write carries a register select code and a 64-bit data word. Register fields are described with MSB-first numbering: field bit 0 is `wr_data[63]`. Each requirement below also gives the equivalent vector index.

A write to the target register is decoded in one of two ways. In full-address mode the word holds a complete register address. That address must point at the core's time-of-day register, and its base is matched against a table of per-core base addresses. In core-index mode a small core number is matched against a table of core identifiers. Either way the result is a core position plus a valid flag, and both are held in registers.

A move command checks four things in turn: the unit is running, the command bit is set, a target has been latched, and that core reports it is ready. When all four hold, the block gives a one-cycle "value sent" pulse to that core. When any check fails, a cause bit is set in a write-one-to-clear error register. A start command moves the unit from stopped to running. A control register keeps the upper half of each word written to it.

Top module: `tod_xfer_ctl`

## Requirements
- R1: After synchronous reset, all of the following are zero: `ctrl_reg`, `err_reg`, `tgt_valid`, `tgt_core`, `tod_run` and `tb_sent`. `tod_run` = 0 means stopped.
- R2: A write with select code 0 (control) loads `wr_data[63:32]` into `ctrl_reg[63:32]` and clears `ctrl_reg[31:0]`.
- R3: A write with select code 1 (target) and `wr_data[28]` set (field bit 35) uses full-address mode. The address is `wr_data[63:32]`.
  - Its low 12 bits must equal parameter `TOD_OFS`, otherwise the target is invalid.
  - Otherwise `{addr[31:12],12'h000}` is matched against `CORE_BASE`.
- R4: With `wr_data[28]` clear, the target write uses core-index mode. `wr_data[36:32]` (the slave-address field masked to 5 bits) is matched against `CORE_ID`. If no entry matches, the target is invalid.
- R5: The lowest-numbered matching table entry wins and is latched in `tgt_core`, with `tgt_valid` = 1. Any invalid target clears `tgt_valid` and sets `err_reg[5]`.
- R6: With parameter `IDX_MODE_EN` = 0, core-index mode always yields an invalid target.
- R7: A write with select code 4 (start) sets `tod_run` when it is 0. If `tod_run` is already 1, it sets `err_reg[4]` instead.
- R8: A write with select code 3 (move) is checked in this order, and the first failing check sets exactly one error bit:
  - not running: `err_reg[0]`;
  - `wr_data[63]` clear: `err_reg[1]`;
  - `tgt_valid` = 0: `err_reg[2]`;
  - `core_ready[tgt_core]` low: `err_reg[3]`.
- R9: When every move check passes, `tb_sent` shows a one-hot pulse on bit `tgt_core`. The pulse appears in the cycle after the write and lasts exactly one cycle.
- R10: A write with select code 2 (error) clears every `err_reg` bit whose `wr_data[5:0]` bit is 1. All other bits keep their value. Error bits set by other commands accumulate.
- R11: Writes with select codes 5 to 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 64 | Write data word |
| core_ready | input | NCORES | Per-core ready-for-value handshake |
| tb_sent | output | NCORES | Per-core value-sent pulse |
| tod_run | output | 1 | Time-of-day running state |
| tgt_valid | output | 1 | Latched target is valid |
| tgt_core | output | IDXW | Latched target core position |
| ctrl_reg | output | 64 | Control register contents |
| err_reg | output | 6 | Error cause register |

## Verification
The bench builds two copies that share all inputs.

- The first copy uses `IDX_MODE_EN` = 1 and a core-ID table in which positions 3 and 7 both carry identifier 3. This duplicate is the only way to observe the lowest-position-wins rule.
- The second copy uses `IDX_MODE_EN` = 0. Every target word is applied to both copies, so the same stimulus shows core-index decoding working on one copy and always rejected on the other.
- The full-address case needs only the default 12-bit offset and the base table.

// File: rtl/tod_xfer_pkg.sv
package tod_xfer_pkg;
  localparam int SEL_W = 3;
  localparam int ERR_W = 6;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_TGT   = 3'd1,
    SEL_ERR   = 3'd2,
    SEL_MOVE  = 3'd3,
    SEL_START = 3'd4
  } reg_sel_e;

  // error cause bit positions
  localparam int E_STATE = 0;
  localparam int E_CMD   = 1;
  localparam int E_NOTGT = 2;
  localparam int E_NRDY  = 3;
  localparam int E_START = 4;
  localparam int E_BADTG = 5;

  // MSB-first field bit n of a 64-bit word -> vector index
  function automatic int fbit(input int n);
    return 63 - n;
  endfunction
endpackage

// File: rtl/tod_core_lookup.sv
module tod_core_lookup #(
  parameter int N  = 8,
  parameter int KW = 32,
  parameter logic [N*KW-1:0] TABLE = '0,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [KW-1:0]   key,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    // scan downward so the lowest matching position is the final winner
    for (int i = N - 1; i >= 0; i--) begin
      if (TABLE[i*KW +: KW] == key) begin
        hit = 1'b1;
        idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/tod_tgt_decode.sv
module tod_tgt_decode #(
  parameter int N = 8,
  parameter logic [11:0] TOD_OFS = 12'h1A1,
  parameter bit IDX_MODE_EN = 1'b1,
  parameter logic [N*32-1:0] CORE_BASE = '0,
  parameter logic [N*5-1:0]  CORE_ID = '0,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [31:0]     addr_word,
  input  logic            full_mode,
  output logic            valid,
  output logic [IDXW-1:0] idx
);
  logic            base_hit;
  logic [IDXW-1:0] base_idx;
  logic            id_hit;
  logic [IDXW-1:0] id_idx;

  tod_core_lookup #(.N(N), .KW(32), .TABLE(CORE_BASE)) u_base (
    .key ({addr_word[31:12], 12'h000}),
    .hit (base_hit),
    .idx (base_idx)
  );

  generate
    if (IDX_MODE_EN) begin : g_idx
      tod_core_lookup #(.N(N), .KW(5), .TABLE(CORE_ID)) u_id (
        .key (addr_word[4:0]),
        .hit (id_hit),
        .idx (id_idx)
      );
    end else begin : g_noidx
      assign id_hit = 1'b0;
      assign id_idx = '0;
    end
  endgenerate

  always_comb begin
    if (full_mode) begin
      valid = base_hit && (addr_word[11:0] == TOD_OFS);
      idx   = base_idx;
    end else begin
      valid = id_hit;
      idx   = id_idx;
    end
  end
endmodule

// File: rtl/tod_xfer_ctl.sv
module tod_xfer_ctl
  import tod_xfer_pkg::*;
#(
  parameter int NCORES = 8,
  parameter logic [11:0] TOD_OFS = 12'h1A1,
  parameter bit IDX_MODE_EN = 1'b1,
  parameter logic [NCORES*32-1:0] CORE_BASE = {
    32'h2700_0000, 32'h2600_0000, 32'h2500_0000, 32'h2400_0000,
    32'h2300_0000, 32'h2200_0000, 32'h2100_0000, 32'h2000_0000},
  parameter logic [NCORES*5-1:0] CORE_ID = {
    5'd11, 5'd10, 5'd9, 5'd8, 5'd3, 5'd2, 5'd1, 5'd0},
  localparam int IDXW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [63:0]       wr_data,
  input  logic [NCORES-1:0] core_ready,
  output logic [NCORES-1:0] tb_sent,
  output logic              tod_run,
  output logic              tgt_valid,
  output logic [IDXW-1:0]   tgt_core,
  output logic [63:0]       ctrl_reg,
  output logic [ERR_W-1:0]  err_reg
);
  logic            dec_valid;
  logic [IDXW-1:0] dec_idx;

  tod_tgt_decode #(
    .N(NCORES), .TOD_OFS(TOD_OFS), .IDX_MODE_EN(IDX_MODE_EN),
    .CORE_BASE(CORE_BASE), .CORE_ID(CORE_ID)
  ) u_dec (
    .addr_word (wr_data[63:32]),
    .full_mode (wr_data[fbit(35)]),
    .valid     (dec_valid),
    .idx       (dec_idx)
  );

  logic [ERR_W-1:0]  err_set, err_clr;
  logic [NCORES-1:0] sent_n;
  logic              run_n;

  always_comb begin
    err_set = '0;
    err_clr = '0;
    sent_n  = '0;
    run_n   = tod_run;
    if (wr_en) begin
      case (wr_sel)
        SEL_TGT:  if (!dec_valid) err_set[E_BADTG] = 1'b1;
        SEL_ERR:  err_clr = wr_data[ERR_W-1:0];
        SEL_START: begin
          if (!tod_run) run_n = 1'b1;
          else          err_set[E_START] = 1'b1;
        end
        SEL_MOVE: begin
          if (!tod_run)                  err_set[E_STATE] = 1'b1;
          else if (!wr_data[fbit(0)])    err_set[E_CMD]   = 1'b1;
          else if (!tgt_valid)           err_set[E_NOTGT] = 1'b1;
          else if (!core_ready[tgt_core]) err_set[E_NRDY] = 1'b1;
          else                           sent_n[tgt_core] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_sent   <= '0;
      tod_run   <= 1'b0;
      tgt_valid <= 1'b0;
      tgt_core  <= '0;
      ctrl_reg  <= '0;
      err_reg   <= '0;
    end else begin
      tb_sent <= sent_n;
      tod_run <= run_n;
      err_reg <= (err_reg & ~err_clr) | err_set;
      if (wr_en && wr_sel == SEL_CTRL)
        ctrl_reg <= {wr_data[63:32], 32'h0};
      if (wr_en && wr_sel == SEL_TGT) begin
        tgt_valid <= dec_valid;
        tgt_core  <= dec_valid ? dec_idx : '0;
      end
    end
  end
endmodule

// File: rtl/tod_xfer_chk.sv
module tod_xfer_chk
  import tod_xfer_pkg::*;
#(
  parameter int NCORES = 8,
  localparam int IDXW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [NCORES-1:0] core_ready,
  input logic [NCORES-1:0] tb_sent,
  input logic              tod_run,
  input logic              tgt_valid,
  input logic [IDXW-1:0]   tgt_core,
  input logic [ERR_W-1:0]  err_reg
);
  AST_SENT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tb_sent)); // R9
  AST_SENT_AFTER_MOVE: assert property (@(posedge clk) disable iff (rst)
    (tb_sent != '0) |-> $past(wr_en && wr_sel == SEL_MOVE && tod_run)); // R9
  AST_SENT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    (tb_sent != '0) |-> (($past(core_ready) & tb_sent) != '0)); // R8
  AST_NO_SENT_INVALID: assert property (@(posedge clk) disable iff (rst)
    !$past(tgt_valid) |-> (tb_sent == '0)); // R8
  AST_RUN_BY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(tod_run) |-> $past(wr_en && wr_sel == SEL_START)); // R7
  AST_ERR_CAUSED: assert property (@(posedge clk) disable iff (rst)
    ((err_reg & ~$past(err_reg)) != '0) |-> $past(wr_en)); // R10
  AST_SENT_HITS_TARGET: assert property (@(posedge clk) disable iff (rst)
    (tb_sent != '0) |-> tb_sent[tgt_core]); // R9
endmodule

bind tod_xfer_ctl tod_xfer_chk #(.NCORES(NCORES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .core_ready(core_ready), .tb_sent(tb_sent), .tod_run(tod_run),
  .tgt_valid(tgt_valid), .tgt_core(tgt_core), .err_reg(err_reg)
);

// File: tb/sim_tod_xfer_ctl.sv
`timescale 1ns/1ps
module sim_tod_xfer_ctl;
  localparam int N = 8;
  localparam logic [N*5-1:0] IDS = {5'd3, 5'd10, 5'd9, 5'd8, 5'd3, 5'd2, 5'd1, 5'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [N-1:0] core_ready = '0;
  logic [N-1:0] sent0, sent1;
  logic run0, run1, val0, val1;
  logic [2:0] core0, core1;
  logic [63:0] ctrl0, ctrl1;
  logic [5:0] err0, err1;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tod_xfer_ctl #(.CORE_ID(IDS)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .core_ready(core_ready), .tb_sent(sent0), .tod_run(run0),
    .tgt_valid(val0), .tgt_core(core0), .ctrl_reg(ctrl0), .err_reg(err0));

  tod_xfer_ctl #(.CORE_ID(IDS), .IDX_MODE_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .core_ready(core_ready), .tb_sent(sent1), .tod_run(run1),
    .tgt_valid(val1), .tgt_core(core1), .ctrl_reg(ctrl1), .err_reg(err1));

  // {data, u0 valid, u0 core, u1 valid}
  localparam int NV = 9;
  localparam logic [68:0] VEC [NV] = '{
    {64'h2300_01A1_1000_0000, 1'b1, 3'd3, 1'b1},  // full, core 3
    {64'h2000_01A1_1000_0000, 1'b1, 3'd0, 1'b1},  // full, core 0
    {64'h2300_01A2_1000_0000, 1'b0, 3'd0, 1'b0},  // bad offset
    {64'h2900_01A1_1000_0000, 1'b0, 3'd0, 1'b0},  // unknown base
    {64'h0000_0008_0000_0000, 1'b1, 3'd4, 1'b0},  // id 8
    {64'h0000_0003_0000_0000, 1'b1, 3'd3, 1'b0},  // id 3 duplicated
    {64'h0000_0028_0000_0000, 1'b1, 3'd4, 1'b0},  // masked to id 8
    {64'h0000_0014_0000_0000, 1'b0, 3'd0, 1'b0},  // id 20 absent
    {64'h0000_000A_0000_0000, 1'b1, 3'd6, 1'b0}   // id 10
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ctrl", ctrl0, 0);
    chk("R1 err", err0, 0);
    chk("R1 valid", val0, 0);
    chk("R1 core", core0, 0);
    chk("R1 run", run0, 0);
    chk("R1 sent", sent0, 0);

    for (int i = 0; i < NV; i++) begin
      wr(3'd1, VEC[i][68:5]);
      chk("R3/R4 valid", val0, VEC[i][4]);
      if (VEC[i][4]) chk("R5 core", core0, VEC[i][3:1]);
      chk("R6 valid", val1, VEC[i][0]);
    end
    chk("R5 bad target err", err0[5], 1);

    wr(3'd0, 64'hDEAD_BEEF_1234_5678);
    chk("R2 ctrl", ctrl0, 64'hDEAD_BEEF_0000_0000);

    wr(3'd2, 64'h3F);
    chk("R10 clear all", err0, 0);

    wr(3'd1, 64'h2300_01A1_1000_0000);
    wr(3'd3, 64'h8000_0000_0000_0000);
    chk("R8 not running", err0, 6'h01);
    chk("R8 no sent", sent0, 0);
    wr(3'd2, 64'h1);

    wr(3'd4, 0);
    chk("R7 start", run0, 1);
    chk("R7 no err", err0, 0);
    wr(3'd4, 0);
    chk("R7 restart err", err0, 6'h10);
    chk("R7 still run", run0, 1);
    wr(3'd2, 64'h3F);

    wr(3'd3, 64'h0);
    chk("R8 cmd bit", err0, 6'h02);
    wr(3'd1, 64'h0000_0014_0000_0000);
    chk("R5 invalid", val0, 0);
    wr(3'd3, 64'h8000_0000_0000_0000);
    chk("R8 no target", err0, 6'h26);
    wr(3'd2, 64'h02);
    chk("R10 partial clear", err0, 6'h24);
    wr(3'd2, 64'h3F);

    wr(3'd1, 64'h2300_01A1_1000_0000);
    core_ready = 8'hF7;
    wr(3'd3, 64'h8000_0000_0000_0000);
    chk("R8 not ready", err0, 6'h08);
    chk("R8 not ready sent", sent0, 0);

    core_ready = 8'h08;
    wr(3'd3, 64'h8000_0000_0000_0000);
    chk("R9 pulse", sent0, 8'h08);
    chk("R10 accumulate", err0, 6'h08);
    @(negedge clk);
    chk("R9 one cycle", sent0, 0);

    wr(3'd1, 64'h0000_000A_0000_0000);
    core_ready = 8'h40;
    wr(3'd3, 64'h8000_0000_0000_0000);
    chk("R9 core 6", sent0, 8'h40);
    chk("R6 idx target rejected", sent1, 0);

    wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R11 ctrl", ctrl0, 64'hDEAD_BEEF_0000_0000);
    chk("R11 err", err0, 6'h08);
    chk("R11 valid", {val0, core0}, {1'b1, 3'd6});
    chk("R11 run", run0, 1);
    chk("R11 sent", sent0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule